// File: doc/BRIEF.md
# Doorbell Sequence Gate

This block sits between a command FIFO and the command execution unit of a flash controller and decides, cycle by cycle, whether the command at the FIFO head may run. It keeps a signed credit count that the host raises by writing signed amounts. Each granted bus-acquire command spends one credit. An acquire command that finds no credit waits at the head until the host adds some. All other commands pass without touching the count.

The host normally loads one or more complete acquire-to-release sequences into the FIFO and then posts their number to the count in a single write. A separate execution-disable input lets the work already queued drain out. Once the FIFO has run empty, it stops further grants while the input stays high. An idle output tells the host when no sequence is open and nothing is queued.

Top module: `seq_doorbell_gate`

## Requirements
- R1: After synchronous reset the count reads 0, no sequence is open and the execution mode is running. With an empty FIFO, idle reads 1.
- R2: A host write adds the written CNT_W-bit two's-complement value to the count on the next clock edge, and the sum wraps modulo 2^CNT_W (127 + 1 gives -128 when CNT_W is 8).
- R3: host_count always shows the current count register, which holds its value in any cycle with no host write and no granted acquire.
- R4: A granted bus-acquire command lowers the count by exactly one on the next edge.
- R5: An acquire at the head is not granted while the count, read as signed, is zero or negative (sign bit set or all bits zero), and the count does not change in such a cycle.
- R6: A non-acquire command at the head is granted whatever the count is, and it leaves the count unchanged.
- R7: When a host write and a granted acquire fall in the same cycle, the count becomes old count plus written value minus one.
- R8: A stalled acquire is granted in the cycle after a host write that brings the count above zero. A write that leaves the count at zero or below keeps it stalled.
- R9: With exec_disable high, commands go on being granted until the FIFO is seen empty. From then on no command is granted while exec_disable stays high, even when new commands arrive.
- R10: After exec_disable falls, grants resume from the following cycle if the FIFO is not empty.
- R11: exec_idle is 1 only when the FIFO is empty and no sequence is open. A sequence opens with a granted acquire and closes with a granted release.
- R12: After the host posts N credits in one write, exactly N acquires are granted before the next acquire stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the credit count |
| host_wr_data | input | CNT_W | Signed amount added to the count |
| host_count | output | CNT_W | Current count (two's complement) |
| exec_disable | input | 1 | Drain the queue, then hold off execution |
| fifo_empty | input | 1 | Command FIFO holds no command |
| head_is_acquire | input | 1 | Head command is a bus-acquire |
| head_is_release | input | 1 | Head command is a bus-release |
| exec_grant | output | 1 | Head command may execute this cycle |
| exec_idle | output | 1 | No open sequence and FIFO empty |

## Verification
The host add and the credit spend driven by a granted acquire can land on the same edge, and each must contribute exactly once. The bench provokes this by holding an acquire at the head of a credited count while writing every 8-bit value. It then compares the result with old count plus value minus one, taken modulo 256. A second sweep runs every start value through a lone acquire and judges the grant against the sign of that value.

// File: rtl/seq_gate_pkg.sv
package seq_gate_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_DRAIN = 2'd1,
        MODE_HALT  = 2'd2
    } gate_mode_e;

    typedef struct packed {
        logic valid;
        logic is_acq;
        logic is_rel;
    } head_cmd_t;

    function automatic gate_mode_e mode_next(input gate_mode_e cur,
                                             input logic dis,
                                             input logic empty);
        gate_mode_e nxt;
        nxt = cur;
        case (cur)
            MODE_RUN:   if (dis) nxt = empty ? MODE_HALT : MODE_DRAIN;
            MODE_DRAIN: if (!dis) nxt = MODE_RUN;
                        else if (empty) nxt = MODE_HALT;
            MODE_HALT:  if (!dis) nxt = MODE_RUN;
            default:    nxt = MODE_HALT;
        endcase
        return nxt;
    endfunction

    function automatic logic mode_allows(input gate_mode_e cur);
        return (cur == MODE_RUN) || (cur == MODE_DRAIN);
    endfunction

endpackage

// File: rtl/seq_gate_credit.sv
module seq_gate_credit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    input  logic             take,
    output logic [CNT_W-1:0] cnt_q,
    output logic             has_credit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] add_term;
    logic [CNT_W-1:0] sub_term;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        add_term   = add_en ? add_val : '0;
        sub_term   = take ? ONE : '0;
        cnt_d      = cnt_q + add_term - sub_term;
        has_credit = !cnt_q[CNT_W-1] && (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/seq_gate_mode.sv
module seq_gate_mode
    import seq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic exec_dis,
    input  logic fifo_empty,
    output logic run_ok
);
    gate_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RUN;
        else     mode_q <= mode_next(mode_q, exec_dis, fifo_empty);
    end

    always_comb run_ok = mode_allows(mode_q);
endmodule

// File: rtl/seq_gate_track.sv
module seq_gate_track
    import seq_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  head_cmd_t head,
    input  logic      grant,
    output logic      idle
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else if (grant && head.is_acq) open_q <= 1'b1;
        else if (grant && head.is_rel) open_q <= 1'b0;
    end

    always_comb idle = !head.valid && !open_q;
endmodule

// File: rtl/seq_doorbell_gate.sv
module seq_doorbell_gate
    import seq_gate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr_en,
    input  logic [CNT_W-1:0] host_wr_data,
    output logic [CNT_W-1:0] host_count,
    input  logic             exec_disable,
    input  logic             fifo_empty,
    input  logic             head_is_acquire,
    input  logic             head_is_release,
    output logic             exec_grant,
    output logic             exec_idle
);
    head_cmd_t head;
    logic      run_ok;
    logic      has_credit;
    logic      take;

    always_comb begin
        head.valid  = !fifo_empty;
        head.is_acq = head_is_acquire;
        head.is_rel = head_is_release;
        exec_grant  = head.valid && run_ok && (!head.is_acq || has_credit);
        take        = exec_grant && head.is_acq;
    end

    seq_gate_credit #(.CNT_W(CNT_W)) u_credit (
        .clk        (clk),
        .rst        (rst),
        .add_en     (host_wr_en),
        .add_val    (host_wr_data),
        .take       (take),
        .cnt_q      (host_count),
        .has_credit (has_credit)
    );

    seq_gate_mode u_mode (
        .clk        (clk),
        .rst        (rst),
        .exec_dis   (exec_disable),
        .fifo_empty (fifo_empty),
        .run_ok     (run_ok)
    );

    seq_gate_track u_track (
        .clk   (clk),
        .rst   (rst),
        .head  (head),
        .grant (exec_grant),
        .idle  (exec_idle)
    );
endmodule

// File: rtl/seq_doorbell_gate_chk.sv
module seq_doorbell_gate_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr_en,
    input logic [CNT_W-1:0] host_wr_data,
    input logic [CNT_W-1:0] host_count,
    input logic             fifo_empty,
    input logic             head_is_acquire,
    input logic             exec_grant,
    input logic             exec_idle
);
    logic spend;
    always_comb spend = exec_grant && head_is_acquire;

    assert_no_credit_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (!fifo_empty && head_is_acquire &&
         (host_count[CNT_W-1] || host_count == '0)) |-> !exec_grant);

    assert_spend_one_R4: assert property (@(posedge clk) disable iff (rst)
        (spend && !host_wr_en) |=> host_count == CNT_W'($past(host_count) - 1'b1));

    assert_host_add_R2: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && !spend) |=>
        host_count == CNT_W'($past(host_count) + $past(host_wr_data)));

    assert_merge_R7: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && spend) |=>
        host_count == CNT_W'($past(host_count) + $past(host_wr_data) - 1'b1));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!host_wr_en && !spend) |=> $stable(host_count));

    assert_idle_empty_R11: assert property (@(posedge clk) disable iff (rst)
        exec_idle |-> fifo_empty);

    assert_empty_no_grant_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !exec_grant);
endmodule

bind seq_doorbell_gate seq_doorbell_gate_chk #(.CNT_W(CNT_W)) i_chk (
    .clk             (clk),
    .rst             (rst),
    .host_wr_en      (host_wr_en),
    .host_wr_data    (host_wr_data),
    .host_count      (host_count),
    .fifo_empty      (fifo_empty),
    .head_is_acquire (head_is_acquire),
    .exec_grant      (exec_grant),
    .exec_idle       (exec_idle)
);

// File: tb/test_seq_doorbell_gate.sv
module test_seq_doorbell_gate;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_wr_en = 1'b0;
    logic [W-1:0] host_wr_data = '0;
    logic [W-1:0] host_count;
    logic         exec_disable = 1'b0;
    logic         fifo_empty = 1'b1;
    logic         head_is_acquire = 1'b0;
    logic         head_is_release = 1'b0;
    logic         exec_grant;
    logic         exec_idle;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_doorbell_gate #(.CNT_W(W)) i_seq_doorbell_gate (
        .clk             (clk),
        .rst             (rst),
        .host_wr_en      (host_wr_en),
        .host_wr_data    (host_wr_data),
        .host_count      (host_count),
        .exec_disable    (exec_disable),
        .fifo_empty      (fifo_empty),
        .head_is_acquire (head_is_acquire),
        .head_is_release (head_is_release),
        .exec_grant      (exec_grant),
        .exec_idle       (exec_idle)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        host_wr_en = 1'b0; host_wr_data = '0; fifo_empty = 1'b1;
        head_is_acquire = 1'b0; head_is_release = 1'b0; exec_disable = 1'b0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1;
        step();
        rst = 1'b0;
        #1;
    endtask

    task automatic host_add(input int v);
        host_wr_en = 1'b1; host_wr_data = W'(v);
        step();
        host_wr_en = 1'b0; host_wr_data = '0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 count", int'(host_count), 0);
        chk("R1 idle", int'(exec_idle), 1);
        fifo_empty = 1'b0; head_is_acquire = 1'b1; #1;
        chk("R1 no grant at zero", int'(exec_grant), 0);

        // R2 R3 R4 R5: every start value through one acquire
        for (int c = 0; c < 256; c++) begin
            do_reset();
            host_add(c);
            chk("R2 R3 count after add", int'(host_count), c);
            fifo_empty = 1'b0; head_is_acquire = 1'b1; #1;
            chk("R5 grant vs sign", int'(exec_grant), (c >= 1 && c <= 127) ? 1 : 0);
            step();
            fifo_empty = 1'b1; head_is_acquire = 1'b0; #1;
            chk("R4 R5 count after acquire", int'(host_count),
                (c >= 1 && c <= 127) ? c - 1 : c);
        end

        // R7: host write merged with a granted acquire
        for (int v = 0; v < 256; v++) begin
            do_reset();
            host_add(3);
            fifo_empty = 1'b0; head_is_acquire = 1'b1;
            host_wr_en = 1'b1; host_wr_data = W'(v); #1;
            chk("R7 grant", int'(exec_grant), 1);
            step();
            idle_inputs(); #1;
            chk("R7 merged count", int'(host_count), (3 + v - 1) & 255);
        end

        // R2 wrap: 127 + 1 -> -128, stalls
        do_reset();
        host_add(127);
        host_add(1);
        chk("R2 wrap", int'(host_count), 128);
        fifo_empty = 1'b0; head_is_acquire = 1'b1; #1;
        chk("R2 R5 wrap stalls", int'(exec_grant), 0);

        // R6: non-acquire commands ignore count
        do_reset();
        host_add(-5);
        fifo_empty = 1'b0; head_is_acquire = 1'b0; #1;
        chk("R6 grant at negative", int'(exec_grant), 1);
        step();
        chk("R6 count untouched", int'(host_count), 251);

        // R8: stall release
        do_reset();
        fifo_empty = 1'b0; head_is_acquire = 1'b1;
        host_add(0);
        chk("R8 zero write stays stalled", int'(exec_grant), 0);
        host_add(-1);
        chk("R8 negative stays stalled", int'(exec_grant), 0);
        host_add(1);
        chk("R8 back to zero stalled", int'(exec_grant), 0);
        chk("R8 count zero", int'(host_count), 0);
        host_wr_en = 1'b1; host_wr_data = 8'd2; #1;
        chk("R8 not released in write cycle", int'(exec_grant), 0);
        step();
        host_wr_en = 1'b0; #1;
        chk("R8 released next cycle", int'(exec_grant), 1);

        // R12 and R11: batch of three sequences
        do_reset();
        host_add(3);
        for (int k = 0; k < 3; k++) begin
            fifo_empty = 1'b0; head_is_acquire = 1'b1; head_is_release = 1'b0; #1;
            chk("R12 acquire granted", int'(exec_grant), 1);
            step();
            fifo_empty = 1'b1; head_is_acquire = 1'b0; #1;
            chk("R11 open sequence not idle", int'(exec_idle), 0);
            fifo_empty = 1'b0; head_is_release = 1'b1; #1;
            chk("R11 release granted", int'(exec_grant), 1);
            step();
            fifo_empty = 1'b1; head_is_release = 1'b0; #1;
            chk("R11 idle after release", int'(exec_idle), 1);
        end
        fifo_empty = 1'b0; head_is_acquire = 1'b1; #1;
        chk("R12 fourth stalls", int'(exec_grant), 0);
        chk("R11 queued not idle", int'(exec_idle), 0);
        chk("R12 count zero", int'(host_count), 0);

        // R9 R10: drain then halt
        do_reset();
        fifo_empty = 1'b0; head_is_acquire = 1'b0; exec_disable = 1'b1; #1;
        chk("R9 drain grant", int'(exec_grant), 1);
        step();
        chk("R9 still draining", int'(exec_grant), 1);
        fifo_empty = 1'b1; #1;
        step();
        fifo_empty = 1'b0; #1;
        chk("R9 halted after empty", int'(exec_grant), 0);
        step();
        step();
        chk("R9 stays halted", int'(exec_grant), 0);
        exec_disable = 1'b0; #1;
        chk("R10 not yet resumed", int'(exec_grant), 0);
        step();
        chk("R10 resumed", int'(exec_grant), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule